// File: doc/BRIEF.md
# Console Register Front End with Receive Interrupt

This block is the register face of a simple character console. A host reaches it through 32-bit word accesses within a 36-byte window. It lets the host send one character straight to a byte output stream. It reports how many received bytes wait in an external receive FIFO. It holds a 64-bit buffer address and a 32-bit byte count for bulk moves.

A command register does four things:

- turns the receive interrupt on;
- turns the receive interrupt off;
- starts a send of a memory buffer to the output;
- starts a fetch of received bytes into memory.

The bulk moves are carried out by a separate transfer engine. This block gives that engine a one-cycle start pulse, the address and the count. It then holds a busy flag until the engine reports completion.

The interrupt is a registered level. It follows the enable state and the occupancy of the receive FIFO. It rises when bytes arrive while enabled, falls when the FIFO drains, and follows each real change of the enable state.

Top module: `tty_mmio_front`

## Requirements
- R1: After reset, `irq`, `tx_valid`, `xfer_busy`, both start pulses, `xfer_ptr`, `xfer_len` and `acc_rdata` are all 0, and the interrupt enable is off.
- R2: A read at byte offset 0x20 returns 1 on `acc_rdata` in the cycle after the access.
- R3: A read at offset 0x04 returns the current `rx_level`, zero-extended, in the cycle after the access.
- R4: Reads at any other offset return 0. This covers write-only offsets, unused offsets, offsets at or above 0x24 and offsets not on a 4-byte boundary.
- R5: A write at offset 0x00 raises `tx_valid` for exactly one cycle, in the cycle after the write, with `tx_byte` equal to bits 7:0 of the written word.
- R6: A write at offset 0x10 sets `xfer_ptr` to the written word zero-extended, so bits 63:32 become 0. A write at offset 0x14 sets `xfer_len`.
- R7: A write at offset 0x18 replaces `xfer_ptr[63:32]` with the written word and leaves bits 31:0 unchanged.
- R8: At offset 0x08, command value 1 turns the interrupt enable on and value 0 turns it off. Repeating the current state has no effect.
- R9: After every clock edge, `irq` equals the enable state AND (`rx_level` sampled at that edge is non-zero). A byte arrival while enabled therefore raises `irq` one cycle later, and draining the FIFO to zero lowers it one cycle later.
- R10: Command value 2 gives a one-cycle `send_start` pulse, and value 3 gives a one-cycle `fetch_start` pulse. Each pulse comes in the cycle after the write. `xfer_busy` goes high with the pulse and stays high until the cycle after `xfer_done`.
- R11: A command write made while `xfer_busy` is high is ignored. It produces no start pulse and no change to the enable state.
- R12: Command values other than 0 to 3 are ignored. Writes to offsets other than 0x00, 0x08, 0x10, 0x14 and 0x18 are ignored. Neither kind changes the outputs or the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe, one word per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid the cycle after a read |
| tx_valid | output | 1 | One-cycle strobe for an output character |
| tx_byte | output | 8 | Output character |
| rx_level | input | LVL_W | Occupancy of the external receive FIFO |
| irq | output | 1 | Level interrupt |
| send_start | output | 1 | Start pulse for a memory-to-output transfer |
| fetch_start | output | 1 | Start pulse for a FIFO-to-memory transfer |
| xfer_ptr | output | 64 | Buffer address for the transfer engine |
| xfer_len | output | 32 | Byte count for the transfer engine |
| xfer_busy | output | 1 | A transfer is in progress |
| xfer_done | input | 1 | Transfer engine reports completion |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it:

- read data after the read access;
- the character strobe, pointer and length updates, start pulses and enable change after the write;
- the interrupt level after a change of `rx_level`;
- the busy clear after `xfer_done`.

The bench drives all inputs on the falling edge and holds them across one rising edge. It checks on the next falling edge, where that single register stage has settled. Where a result must last only one cycle (the character strobe, the start pulses), a second check one falling edge later confirms it has dropped.

// File: rtl/tty_mmio_pkg.sv
package tty_mmio_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PUTC,
      SEL_LEVEL,
      SEL_CMD,
      SEL_PTR_LO,
      SEL_LEN,
      SEL_PTR_HI,
      SEL_VER
   } reg_sel_e;

   localparam logic [31:0] CMD_IRQ_OFF = 32'd0;
   localparam logic [31:0] CMD_IRQ_ON  = 32'd1;
   localparam logic [31:0] CMD_SEND    = 32'd2;
   localparam logic [31:0] CMD_FETCH   = 32'd3;

endpackage

// File: rtl/tty_mmio_decode.sv
module tty_mmio_decode
   import tty_mmio_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   localparam logic [ADDR_W-1:0] WINDOW = ADDR_W'(36);

   always_comb begin
      sel = SEL_NONE;
      if (addr[1:0] == 2'b00 && addr < WINDOW) begin
         case (addr[5:2])
            4'd0:    sel = SEL_PUTC;
            4'd1:    sel = SEL_LEVEL;
            4'd2:    sel = SEL_CMD;
            4'd4:    sel = SEL_PTR_LO;
            4'd5:    sel = SEL_LEN;
            4'd6:    sel = SEL_PTR_HI;
            4'd8:    sel = SEL_VER;
            default: sel = SEL_NONE;
         endcase
      end
   end
endmodule

// File: rtl/tty_ptr_len_regs.sv
module tty_ptr_len_regs
   import tty_mmio_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PTR_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [PTR_W-1:0]  ptr,
   output logic [DATA_W-1:0] len
);
   localparam int HI_W = PTR_W - DATA_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         len <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_PTR_LO: ptr <= {{HI_W{1'b0}}, wdata};
            SEL_PTR_HI: ptr <= {wdata[HI_W-1:0], ptr[DATA_W-1:0]};
            SEL_LEN:    len <= wdata;
            default:    ;
         endcase
      end
   end

   AST_LO_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_PTR_LO) |=> (ptr[PTR_W-1:DATA_W] == '0)); // R6
   AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_PTR_HI) |=> (ptr[DATA_W-1:0] == $past(ptr[DATA_W-1:0]))); // R7
endmodule

// File: rtl/tty_cmd_irq.sv
module tty_cmd_irq
   import tty_mmio_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LVL_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_we,
   input  logic [DATA_W-1:0] cmd,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic              xfer_done,
   output logic              irq,
   output logic              send_start,
   output logic              fetch_start,
   output logic              busy
);
   logic irq_en_q, irq_en_nx, accept;

   assign accept = cmd_we && !busy;

   always_comb begin
      irq_en_nx = irq_en_q;
      if (accept && cmd == CMD_IRQ_ON)  irq_en_nx = 1'b1;
      if (accept && cmd == CMD_IRQ_OFF) irq_en_nx = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en_q    <= 1'b0;
         irq         <= 1'b0;
         send_start  <= 1'b0;
         fetch_start <= 1'b0;
         busy        <= 1'b0;
      end else begin
         irq_en_q    <= irq_en_nx;
         irq         <= irq_en_nx && (rx_level != '0);
         send_start  <= accept && cmd == CMD_SEND;
         fetch_start <= accept && cmd == CMD_FETCH;
         if (accept && (cmd == CMD_SEND || cmd == CMD_FETCH)) busy <= 1'b1;
         else if (xfer_done)                                    busy <= 1'b0;
      end
   end

   AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({send_start, fetch_start})); // R10
   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (send_start || fetch_start) |-> busy); // R10
   AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (send_start || fetch_start) |-> !$past(busy)); // R11
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en_q); // R9
endmodule

// File: rtl/tty_mmio_front.sv
module tty_mmio_front
   import tty_mmio_pkg::*;
#(
   parameter int          ADDR_W     = 6,
   parameter int          FIFO_DEPTH = 16,
   parameter logic [31:0] VERSION    = 32'd1,
   parameter bit          READ_PIPE  = 1'b1,
   parameter int          PTR_W      = 64,
   parameter int          LEN_W      = 32,
   localparam int         DATA_W     = 32,
   localparam int         LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_byte,
   input  logic [LVL_W-1:0]  rx_level,
   output logic              irq,
   output logic              send_start,
   output logic              fetch_start,
   output logic [PTR_W-1:0]  xfer_ptr,
   output logic [LEN_W-1:0]  xfer_len,
   output logic              xfer_busy,
   input  logic              xfer_done
);
   generate
      if (ADDR_W < 6)           begin : g_bad_addr  $error("ADDR_W must be at least 6"); end
      if (FIFO_DEPTH < 1)       begin : g_bad_depth $error("FIFO_DEPTH must be positive"); end
      if (PTR_W != 2 * DATA_W)  begin : g_bad_ptr   $error("PTR_W must be twice the word"); end
      if (LEN_W != DATA_W)      begin : g_bad_len   $error("LEN_W must equal the word"); end
      if (LVL_W > DATA_W)       begin : g_bad_lvl   $error("FIFO level too wide"); end
   endgenerate

   reg_sel_e          sel;
   logic              wr_en, rd_en;
   logic [DATA_W-1:0] rd_mux;

   assign wr_en = acc_valid && acc_write;
   assign rd_en = acc_valid && !acc_write;

   tty_mmio_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (acc_addr),
      .sel  (sel)
   );

   tty_ptr_len_regs #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .sel   (sel),
      .wdata (acc_wdata),
      .ptr   (xfer_ptr),
      .len   (xfer_len)
   );

   tty_cmd_irq #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_cmd (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_we      (wr_en && sel == SEL_CMD),
      .cmd         (acc_wdata),
      .rx_level    (rx_level),
      .xfer_done   (xfer_done),
      .irq         (irq),
      .send_start  (send_start),
      .fetch_start (fetch_start),
      .busy        (xfer_busy)
   );

   always_comb begin
      case (sel)
         SEL_LEVEL: rd_mux = DATA_W'(rx_level);
         SEL_VER:   rd_mux = VERSION;
         default:   rd_mux = '0;
      endcase
   end

   generate
      if (READ_PIPE) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n)     acc_rdata <= '0;
            else if (rd_en) acc_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign acc_rdata = rd_en ? rd_mux : '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_byte  <= '0;
      end else begin
         tx_valid <= wr_en && sel == SEL_PUTC;
         if (wr_en && sel == SEL_PUTC) tx_byte <= acc_wdata[7:0];
      end
   end

   AST_TX_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (tx_byte == $past(acc_wdata[7:0]))); // R5
   AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(acc_valid && acc_write)); // R5
endmodule

// File: tb/tb_tty_mmio_front.sv
module tb_tty_mmio_front;
   localparam int LVL_W = 5;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        acc_valid, acc_write;
   logic [5:0]  acc_addr;
   logic [31:0] acc_wdata, acc_rdata;
   logic        tx_valid;
   logic [7:0]  tx_byte;
   logic [LVL_W-1:0] rx_level;
   logic        irq, send_start, fetch_start, xfer_busy, xfer_done;
   logic [63:0] xfer_ptr;
   logic [31:0] xfer_len;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;

   tty_mmio_front dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_level(rx_level), .irq(irq),
      .send_start(send_start), .fetch_start(fetch_start), .xfer_ptr(xfer_ptr),
      .xfer_len(xfer_len), .xfer_busy(xfer_busy), .xfer_done(xfer_done)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic bus_rd(input logic [5:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
      @(negedge clk);
      acc_valid = 1'b0;
      check(acc_rdata == exp, req, acc_rdata, exp);
   endtask

   task automatic t_reset;
      check(irq == 1'b0 && tx_valid == 1'b0 && xfer_busy == 1'b0, "R1 ctl", {irq, tx_valid, xfer_busy}, 0);
      check(send_start == 1'b0 && fetch_start == 1'b0, "R1 start", {send_start, fetch_start}, 0);
      check(xfer_ptr == 64'd0, "R1 ptr", xfer_ptr, 0);
      check(xfer_len == 32'd0, "R1 len", xfer_len, 0);
      check(acc_rdata == 32'd0, "R1 rdata", acc_rdata, 0);
   endtask

   task automatic t_reads;
      rx_level = 5'd5;
      bus_rd(6'h20, 32'd1, "R2 version");
      bus_rd(6'h04, 32'd5, "R3 level 5");
      rx_level = 5'd16;
      bus_rd(6'h04, 32'd16, "R3 level full");
      bus_rd(6'h00, 32'd0, "R4 putc offset");
      bus_rd(6'h10, 32'd0, "R4 ptr offset");
      bus_rd(6'h1C, 32'd0, "R4 unused");
      bus_rd(6'h22, 32'd0, "R4 unaligned");
      bus_rd(6'h24, 32'd0, "R4 past window");
      bus_rd(6'h3C, 32'd0, "R4 high offset");
      rx_level = 5'd0;
   endtask

   task automatic t_putc;
      bus_wr(6'h00, 32'hABCD_1234);
      check(tx_valid == 1'b1 && tx_byte == 8'h34, "R5 strobe", {tx_valid, tx_byte}, 9'h134);
      @(negedge clk);
      check(tx_valid == 1'b0, "R5 one cycle", tx_valid, 0);
      bus_wr(6'h00, 32'h0000_00FF);
      check(tx_valid == 1'b1 && tx_byte == 8'hFF, "R5 second", {tx_valid, tx_byte}, 9'h1FF);
   endtask

   task automatic t_ptr;
      bus_wr(6'h18, 32'hDEAD_0001);
      check(xfer_ptr == 64'hDEAD_0001_0000_0000, "R7 hi first", xfer_ptr, 64'hDEAD_0001_0000_0000);
      bus_wr(6'h10, 32'h1122_3344);
      check(xfer_ptr == 64'h0000_0000_1122_3344, "R6 lo clears hi", xfer_ptr, 64'h1122_3344);
      bus_wr(6'h18, 32'h0000_0055);
      check(xfer_ptr == 64'h0000_0055_1122_3344, "R7 hi keeps lo", xfer_ptr, 64'h0000_0055_1122_3344);
      bus_wr(6'h14, 32'h0000_0100);
      check(xfer_len == 32'h100, "R6 len", xfer_len, 32'h100);
   endtask

   task automatic t_ignored_writes;
      bus_wr(6'h0C, 32'hFFFF_FFFF);
      check(xfer_ptr == 64'h0000_0055_1122_3344 && xfer_len == 32'h100 && !tx_valid,
            "R12 undefined offset", xfer_ptr, 64'h0000_0055_1122_3344);
      bus_wr(6'h20, 32'h0000_0007);
      check(xfer_len == 32'h100 && !irq && !xfer_busy, "R12 version write", xfer_len, 32'h100);
      bus_wr(6'h12, 32'h0000_0000);
      check(xfer_ptr == 64'h0000_0055_1122_3344, "R12 unaligned write", xfer_ptr, 64'h0000_0055_1122_3344);
   endtask

   task automatic t_irq;
      rx_level = 5'd0;
      bus_wr(6'h08, 32'd1);
      check(irq == 1'b0, "R9 enabled empty", irq, 0);
      rx_level = 5'd3;
      @(negedge clk);
      check(irq == 1'b1, "R9 arrival", irq, 1);
      bus_wr(6'h08, 32'd0);
      check(irq == 1'b0, "R8 disable", irq, 0);
      bus_wr(6'h08, 32'd0);
      check(irq == 1'b0, "R8 disable twice", irq, 0);
      bus_wr(6'h08, 32'd1);
      check(irq == 1'b1, "R8 enable nonempty", irq, 1);
      bus_wr(6'h08, 32'd1);
      check(irq == 1'b1, "R8 enable twice", irq, 1);
      bus_wr(6'h08, 32'd7);
      check(irq == 1'b1 && !send_start && !fetch_start && !xfer_busy, "R12 unknown cmd",
            {irq, send_start, fetch_start, xfer_busy}, 4'b1000);
      bus_wr(6'h08, 32'h0000_0100);
      check(irq == 1'b1 && !xfer_busy, "R12 wide cmd", {irq, xfer_busy}, 2'b10);
   endtask

   task automatic t_fetch;
      bus_wr(6'h08, 32'd3);
      check(fetch_start && !send_start && xfer_busy, "R10 fetch pulse",
            {fetch_start, send_start, xfer_busy}, 3'b101);
      @(negedge clk);
      check(!fetch_start && xfer_busy, "R10 fetch one cycle", {fetch_start, xfer_busy}, 2'b01);
      bus_wr(6'h08, 32'd0);
      check(irq == 1'b1, "R11 disable while busy", irq, 1);
      bus_wr(6'h08, 32'd2);
      check(!send_start && !fetch_start, "R11 send while busy", {send_start, fetch_start}, 0);
      rx_level = 5'd0;
      @(negedge clk);
      check(irq == 1'b0, "R9 drain", irq, 0);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      check(xfer_busy == 1'b0, "R10 done clears busy", xfer_busy, 0);
      rx_level = 5'd1;
      @(negedge clk);
      check(irq == 1'b1, "R11 enable kept", irq, 1);
   endtask

   task automatic t_send;
      bus_wr(6'h08, 32'd2);
      check(send_start && !fetch_start && xfer_busy, "R10 send pulse",
            {send_start, fetch_start, xfer_busy}, 3'b101);
      check(xfer_ptr == 64'h0000_0055_1122_3344 && xfer_len == 32'h100, "R10 send args",
            xfer_len, 32'h100);
      @(negedge clk);
      check(!send_start, "R10 send one cycle", send_start, 0);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      check(!xfer_busy, "R10 send done", xfer_busy, 0);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
      acc_wdata = '0; rx_level = '0; xfer_done = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reads();
      t_putc();
      t_ptr();
      t_ignored_writes();
      t_irq();
      t_fetch();
      t_send();
      finish_run();
   end
endmodule